// File: doc/BRIEF.md
# Processor Debug Event Controller

This block sits beside a processor pipeline and turns raw debug event strobes into debug actions. The pipeline and the address and value comparators report events as single-cycle strobes. Each strobe is gated by its own enable bit, taken from one of two control words. An enabled event sets its bit in a sticky status word. Software clears that word by writing ones to the bits it wants cleared.

Three mode inputs decide what an enabled event does:

- Internal mode raises a debug interrupt request.
- External mode halts the core. If internal mode is also on, the interrupt is left pending.
- Wait mode, with the other two modes off, stops the core until an interrupt wake arrives.
- With every mode off, the event is only recorded.

A pending interrupt is delivered only while the machine-state debug-enable input is 1. An event that occurs while that input is 0 also sets an imprecise flag in the status word.

Top module: `dbg_event_ctrl`

## Requirements
- R1: Status bit layout: 0 instruction complete, 1 branch taken, 2 exception, 3 trap, 4 unconditional, 5..8 instruction address channels 1..4, 9..10 data address channels 1..2, 11 imprecise. Pipeline strobe `evt_i` bits are 0 complete, 1 branch, 2 exception, 3 trap, 4..7 instruction address channels 1..4, 8..9 data address channels 1..2. A strobe sets its status bit on the next clock only if its enable bit is 1. `en_core_i` bits 0..4 enable complete, branch, exception, trap and unconditional. `en_cmp_i` bits 0..5 enable the six comparator channels in the same channel order.
- R2: Status bits are sticky. A write with `clr_we_i`=1 clears the bits set in `clr_mask_i`. A new event on a bit in the same cycle wins over the clear.
- R3: With internal, external and wait modes all 0, events are recorded but `halt_o` and `dbg_irq_o` stay 0.
- R4: With internal mode only, an enabled event makes `dbg_irq_o` 1 from the next cycle, while `msr_de_i` is 1.
- R5: With external mode on, an enabled event sets `halt_o` on the next clock. Outside wait mode, `halt_o` is released only by `resume_i`, and `wake_irq_i` has no effect on it.
- R6: With internal and external modes both on, an event halts the core and leaves the interrupt pending. `dbg_irq_o` stays 0 while halted and rises after resume if `msr_de_i` is 1.
- R7: With internal and external modes 0 and wait mode 1, an event sets `halt_o`. `wake_irq_i` releases it.
- R8: A pending interrupt is held while `msr_de_i` is 0 and appears when `msr_de_i` becomes 1. It is withdrawn once bits 0..10 of the status word are all clear.
- R9: Any enabled event that occurs while `msr_de_i` is 0 also sets status bit 11.
- R10: The instruction-complete event is ignored when internal mode is 1, external mode is 0 and `msr_de_i` is 0.
- R11: `uncond_req_i`, gated by `en_core_i[4]`, is recorded in bit 4 and acts like any other event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | 10 | Pipeline and comparator event strobes |
| uncond_req_i | input | 1 | Unconditional request from the external debug port |
| en_core_i | input | 5 | Enables for complete, branch, exception, trap and unconditional |
| en_cmp_i | input | 6 | Enables for the comparator channels |
| int_mode_i | input | 1 | Internal debug mode |
| ext_mode_i | input | 1 | External debug mode |
| wait_mode_i | input | 1 | Wait mode |
| msr_de_i | input | 1 | Machine-state debug-enable bit |
| resume_i | input | 1 | External resume strobe |
| wake_irq_i | input | 1 | Interrupt wake for wait mode |
| clr_we_i | input | 1 | Status clear strobe |
| clr_mask_i | input | 12 | Write-one-to-clear mask |
| dbg_irq_o | output | 1 | Debug interrupt request |
| halt_o | output | 1 | Core halt |
| status_o | output | 12 | Sticky event status |

## Verification
The main function is driven with single events under each mode combination: record-only, internal, external, internal plus external, and wait. This shows that the mode bits, rather than the event type, select between interrupt, halt and recording. The same events are also driven with their enable cleared, or with a different channel enabled, which shows that gating works per bit. The event completion strobe is run with the debug-enable bit at 0 under internal mode alone and under combined modes, which separates the suppression case from the imprecise-flag case. An all-events burst checks the bit layout. Directed cases then cover which release input frees each kind of halt, a clear that collides with a new event, and a pending interrupt held by the debug-enable bit.

// File: rtl/dbg_evt_pkg.sv
package dbg_evt_pkg;
  localparam int unsigned N_IAC   = 4;
  localparam int unsigned N_DAC   = 2;
  localparam int unsigned N_CORE  = 4;               // complete, branch, exception, trap
  localparam int unsigned N_CMP   = N_IAC + N_DAC;
  localparam int unsigned N_PIPE  = N_CORE + N_CMP;  // strobes on evt_i
  localparam int unsigned N_EVT   = N_PIPE + 1;      // plus unconditional
  localparam int unsigned ST_W    = N_EVT + 1;       // plus imprecise
  localparam int unsigned B_ICMP  = 0;
  localparam int unsigned B_UNC   = N_CORE;
  localparam int unsigned B_CMP0  = N_CORE + 1;
  localparam int unsigned B_IMP   = N_EVT;

  typedef enum logic [1:0] {
    ACT_RECORD = 2'd0,
    ACT_IRQ    = 2'd1,
    ACT_HALT   = 2'd2,
    ACT_WAIT   = 2'd3
  } dbg_act_e;
endpackage

// File: rtl/dbg_evt_gate.sv
module dbg_evt_gate
  import dbg_evt_pkg::*;
(
  input  logic [N_PIPE-1:0] evt_i,
  input  logic              uncond_i,
  input  logic [N_CORE:0]   en_core_i,
  input  logic [N_CMP-1:0]  en_cmp_i,
  input  logic              int_mode_i,
  input  logic              ext_mode_i,
  input  logic              msr_de_i,
  output logic [N_EVT-1:0]  hit_o
);
  logic icmp_block;
  assign icmp_block = int_mode_i & ~ext_mode_i & ~msr_de_i;

  for (genvar i = 0; i < N_CORE; i++) begin : g_core
    if (i == B_ICMP) begin : g_icmp
      assign hit_o[i] = evt_i[i] & en_core_i[i] & ~icmp_block;
    end else begin : g_plain
      assign hit_o[i] = evt_i[i] & en_core_i[i];
    end
  end

  assign hit_o[B_UNC] = uncond_i & en_core_i[N_CORE];

  for (genvar c = 0; c < N_CMP; c++) begin : g_cmp
    assign hit_o[B_CMP0+c] = evt_i[N_CORE+c] & en_cmp_i[c];
  end
endmodule

// File: rtl/dbg_status_reg.sv
module dbg_status_reg
  import dbg_evt_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_EVT-1:0] hit_i,
  input  logic             msr_de_i,
  input  logic             clr_we_i,
  input  logic [ST_W-1:0]  clr_mask_i,
  output logic [ST_W-1:0]  status_o,
  output logic             any_evt_o
);
  logic [ST_W-1:0] set_v;
  logic [ST_W-1:0] clr_v;
  logic [ST_W-1:0] st_q;

  assign set_v = {(|hit_i) & ~msr_de_i, hit_i};
  assign clr_v = clr_we_i ? clr_mask_i : '0;

  for (genvar b = 0; b < ST_W; b++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       st_q[b] <= 1'b0;
      else if (set_v[b]) st_q[b] <= 1'b1;   // new event beats clear
      else if (clr_v[b]) st_q[b] <= 1'b0;
    end
  end

  assign status_o  = st_q;
  assign any_evt_o = |st_q[N_EVT-1:0];
endmodule

// File: rtl/dbg_action_ctrl.sv
module dbg_action_ctrl
  import dbg_evt_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hit_any_i,
  input  logic int_mode_i,
  input  logic ext_mode_i,
  input  logic wait_mode_i,
  input  logic msr_de_i,
  input  logic resume_i,
  input  logic wake_irq_i,
  input  logic any_evt_i,
  output logic irq_o,
  output logic halt_o
);
  dbg_act_e act;
  logic halt_q, wait_q, pend_q;
  logic halt_d, wait_d, pend_d, release_w;

  always_comb begin
    if (ext_mode_i)                    act = ACT_HALT;
    else if (int_mode_i)               act = ACT_IRQ;
    else if (wait_mode_i)              act = ACT_WAIT;
    else                               act = ACT_RECORD;
  end

  assign release_w = wait_q ? wake_irq_i : resume_i;

  always_comb begin
    halt_d = halt_q & ~release_w;
    wait_d = wait_q & halt_d;
    if (hit_any_i && (act == ACT_HALT || act == ACT_WAIT)) begin
      halt_d = 1'b1;
      wait_d = (act == ACT_WAIT);
    end
    pend_d = pend_q & any_evt_i;        // withdrawn once status events clear
    if (hit_any_i && int_mode_i) pend_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      halt_q <= 1'b0;
      wait_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      halt_q <= halt_d;
      wait_q <= wait_d;
      pend_q <= pend_d;
    end
  end

  assign halt_o = halt_q;
  assign irq_o  = pend_q & msr_de_i & ~halt_q;
endmodule

// File: rtl/dbg_event_ctrl.sv
module dbg_event_ctrl
  import dbg_evt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_PIPE-1:0] evt_i,
  input  logic              uncond_req_i,
  input  logic [N_CORE:0]   en_core_i,
  input  logic [N_CMP-1:0]  en_cmp_i,
  input  logic              int_mode_i,
  input  logic              ext_mode_i,
  input  logic              wait_mode_i,
  input  logic              msr_de_i,
  input  logic              resume_i,
  input  logic              wake_irq_i,
  input  logic              clr_we_i,
  input  logic [ST_W-1:0]   clr_mask_i,
  output logic              dbg_irq_o,
  output logic              halt_o,
  output logic [ST_W-1:0]   status_o
);
  logic [N_EVT-1:0] hit;
  logic             any_evt;

  dbg_evt_gate u_gate (
    .evt_i      (evt_i),
    .uncond_i   (uncond_req_i),
    .en_core_i  (en_core_i),
    .en_cmp_i   (en_cmp_i),
    .int_mode_i (int_mode_i),
    .ext_mode_i (ext_mode_i),
    .msr_de_i   (msr_de_i),
    .hit_o      (hit)
  );

  dbg_status_reg u_status (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .hit_i      (hit),
    .msr_de_i   (msr_de_i),
    .clr_we_i   (clr_we_i),
    .clr_mask_i (clr_mask_i),
    .status_o   (status_o),
    .any_evt_o  (any_evt)
  );

  dbg_action_ctrl u_action (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .hit_any_i   (|hit),
    .int_mode_i  (int_mode_i),
    .ext_mode_i  (ext_mode_i),
    .wait_mode_i (wait_mode_i),
    .msr_de_i    (msr_de_i),
    .resume_i    (resume_i),
    .wake_irq_i  (wake_irq_i),
    .any_evt_i   (any_evt),
    .irq_o       (dbg_irq_o),
    .halt_o      (halt_o)
  );
endmodule

// File: rtl/dbg_event_ctrl_chk.sv
module dbg_event_ctrl_chk
  import dbg_evt_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic [N_PIPE-1:0] evt_i,
  input logic [N_CORE:0]   en_core_i,
  input logic              int_mode_i,
  input logic              ext_mode_i,
  input logic              wait_mode_i,
  input logic              msr_de_i,
  input logic              resume_i,
  input logic              wake_irq_i,
  input logic              clr_we_i,
  input logic              dbg_irq_o,
  input logic              halt_o,
  input logic [ST_W-1:0]   status_o
);
  p_branch_rec_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i[1] && en_core_i[1]) |=> status_o[1]);

  p_sticky_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_we_i |=> ((status_o & $past(status_o)) == $past(status_o)));

  p_idle_no_halt_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!halt_o && !int_mode_i && !ext_mode_i && !wait_mode_i) |=> !halt_o);

  p_halt_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halt_o && !resume_i && !wake_irq_i) |=> halt_o);

  p_irq_masked_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dbg_irq_o |-> msr_de_i);

  p_imprecise_src_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status_o[B_IMP]) |-> !$past(msr_de_i));
endmodule

bind dbg_event_ctrl dbg_event_ctrl_chk u_chk (.*);

// File: tb/dbg_event_ctrl_test.sv
module dbg_event_ctrl_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [9:0]  evt_i = '0;
  logic        uncond_req_i = 1'b0;
  logic [4:0]  en_core_i = '0;
  logic [5:0]  en_cmp_i = '0;
  logic        int_mode_i = 1'b0, ext_mode_i = 1'b0, wait_mode_i = 1'b0;
  logic        msr_de_i = 1'b1, resume_i = 1'b0, wake_irq_i = 1'b0;
  logic        clr_we_i = 1'b0;
  logic [11:0] clr_mask_i = '0;
  logic        dbg_irq_o, halt_o;
  logic [11:0] status_o;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  dbg_event_ctrl uut (.*);

  typedef struct packed {
    logic [3:0]  rq;
    logic [9:0]  ev;
    logic        un;
    logic [4:0]  e0;
    logic [5:0]  e1;
    logic [2:0]  md;   // {int, ext, wait}
    logic        de;
    logic [11:0] st;
    logic        hl;
    logic        iq;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VT [NV] = '{
    '{4'd3,  10'h002, 1'b0, 5'h02, 6'h00, 3'b000, 1'b1, 12'h002, 1'b0, 1'b0}, // R3 record only
    '{4'd1,  10'h002, 1'b0, 5'h1D, 6'h3F, 3'b100, 1'b1, 12'h000, 1'b0, 1'b0}, // R1 branch disabled
    '{4'd4,  10'h002, 1'b0, 5'h02, 6'h00, 3'b100, 1'b1, 12'h002, 1'b0, 1'b1}, // R4 interrupt
    '{4'd9,  10'h004, 1'b0, 5'h04, 6'h00, 3'b100, 1'b0, 12'h804, 1'b0, 1'b0}, // R9 imprecise, R8 held
    '{4'd5,  10'h008, 1'b0, 5'h08, 6'h00, 3'b010, 1'b1, 12'h008, 1'b1, 1'b0}, // R5 halt
    '{4'd6,  10'h020, 1'b0, 5'h00, 6'h02, 3'b110, 1'b1, 12'h040, 1'b1, 1'b0}, // R6 halt + pending
    '{4'd7,  10'h200, 1'b0, 5'h00, 6'h20, 3'b001, 1'b1, 12'h400, 1'b1, 1'b0}, // R7 wait halt
    '{4'd10, 10'h001, 1'b0, 5'h01, 6'h00, 3'b100, 1'b0, 12'h000, 1'b0, 1'b0}, // R10 suppressed
    '{4'd10, 10'h001, 1'b0, 5'h01, 6'h00, 3'b110, 1'b0, 12'h801, 1'b1, 1'b0}, // R10 not suppressed
    '{4'd11, 10'h000, 1'b1, 5'h10, 6'h00, 3'b010, 1'b1, 12'h010, 1'b1, 1'b0}, // R11 unconditional
    '{4'd1,  10'h3FF, 1'b1, 5'h1F, 6'h3F, 3'b000, 1'b1, 12'h7FF, 1'b0, 1'b0}, // R1 layout
    '{4'd1,  10'h080, 1'b0, 5'h00, 6'h01, 3'b001, 1'b1, 12'h000, 1'b0, 1'b0}  // R1 wrong channel
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    evt_i = '0; uncond_req_i = 1'b0; resume_i = 1'b0; wake_irq_i = 1'b0;
    clr_we_i = 1'b0; clr_mask_i = '0;
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic pulse(input logic [9:0] ev, input logic un);
    @(negedge clk_i);
    evt_i = ev; uncond_req_i = un;
    @(negedge clk_i);
    evt_i = '0; uncond_req_i = 1'b0;
  endtask

  task automatic set_mode(input logic [2:0] md, input logic de);
    {int_mode_i, ext_mode_i, wait_mode_i} = md;
    msr_de_i = de;
  endtask

  initial begin
    #(5ns * 20000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    do_reset();
    chk("R1 reset status", status_o, 12'h000);
    chk("R5 reset halt", halt_o, 1'b0);
    chk("R4 reset irq", dbg_irq_o, 1'b0);

    for (int i = 0; i < NV; i++) begin
      do_reset();
      en_core_i = VT[i].e0; en_cmp_i = VT[i].e1;
      set_mode(VT[i].md, VT[i].de);
      pulse(VT[i].ev, VT[i].un);
      chk($sformatf("R%0d vec%0d status", VT[i].rq, i), status_o, VT[i].st);
      chk($sformatf("R%0d vec%0d halt", VT[i].rq, i), halt_o, VT[i].hl);
      chk($sformatf("R%0d vec%0d irq", VT[i].rq, i), dbg_irq_o, VT[i].iq);
    end

    // R8: pending held while DE=0, delivered when DE rises, dropped after clear
    do_reset();
    en_core_i = 5'h04; en_cmp_i = '0; set_mode(3'b100, 1'b0);
    pulse(10'h004, 1'b0);
    repeat (3) @(negedge clk_i);
    chk("R8 held while masked", dbg_irq_o, 1'b0);
    msr_de_i = 1'b1; #1;
    chk("R8 delivered on unmask", dbg_irq_o, 1'b1);
    clr_we_i = 1'b1; clr_mask_i = 12'hFFF;
    @(negedge clk_i);
    clr_we_i = 1'b0; clr_mask_i = '0;
    chk("R2 cleared all", status_o, 12'h000);
    @(negedge clk_i);
    chk("R8 withdrawn after clear", dbg_irq_o, 1'b0);

    // R5: external halt ignores wake, released by resume
    do_reset();
    en_core_i = 5'h08; set_mode(3'b010, 1'b1);
    pulse(10'h008, 1'b0);
    wake_irq_i = 1'b1;
    repeat (2) @(negedge clk_i);
    wake_irq_i = 1'b0;
    chk("R5 wake ignored", halt_o, 1'b1);
    resume_i = 1'b1; @(negedge clk_i); resume_i = 1'b0;
    chk("R5 resume releases", halt_o, 1'b0);

    // R6: interrupt appears after resume
    do_reset();
    en_cmp_i = 6'h02; set_mode(3'b110, 1'b1);
    pulse(10'h020, 1'b0);
    repeat (2) @(negedge clk_i);
    chk("R6 irq blocked while halted", dbg_irq_o, 1'b0);
    resume_i = 1'b1; @(negedge clk_i); resume_i = 1'b0;
    chk("R6 halt released", halt_o, 1'b0);
    chk("R6 pending delivered", dbg_irq_o, 1'b1);

    // R7: wait halt released by wake
    do_reset();
    en_cmp_i = 6'h20; set_mode(3'b001, 1'b1);
    pulse(10'h200, 1'b0);
    repeat (2) @(negedge clk_i);
    chk("R7 wait holds", halt_o, 1'b1);
    wake_irq_i = 1'b1; @(negedge clk_i); wake_irq_i = 1'b0;
    chk("R7 wake releases", halt_o, 1'b0);

    // R2: partial clear and event-over-clear priority
    do_reset();
    en_core_i = 5'h06; en_cmp_i = '0; set_mode(3'b000, 1'b1);
    pulse(10'h006, 1'b0);
    chk("R2 both set", status_o, 12'h006);
    clr_we_i = 1'b1; clr_mask_i = 12'h002;
    @(negedge clk_i);
    clr_we_i = 1'b0; clr_mask_i = '0;
    chk("R2 partial clear", status_o, 12'h004);
    clr_we_i = 1'b1; clr_mask_i = 12'h004; evt_i = 10'h004;
    @(negedge clk_i);
    clr_we_i = 1'b0; clr_mask_i = '0; evt_i = '0;
    chk("R2 event beats clear", status_o, 12'h004);
    repeat (3) @(negedge clk_i);
    chk("R2 sticky", status_o, 12'h004);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule